// File: doc/BRIEF.md
# RV32 Integer ALU Instruction Executor

This block executes one 32-bit RV32I instruction word per clock against its own 32-entry, 32-bit register file. Only two instruction classes are handled. The first is register-register arithmetic and logic (opcode 0110011). The second is register-immediate arithmetic and logic (opcode 0010011). The block splits the word into its fields, reads the source operands, computes the result and writes it to the destination register on the next rising clock edge.

Each cycle the block also reports, combinationally, which class the presented word belongs to and whether the word is illegal. A combinational debug read port exposes any register, so that a test environment or a neighbouring block can observe the architectural state. There is no program counter and no fetch. The surrounding logic presents instruction words and qualifies each one with a valid strobe.

The block has no sequencing state beyond the register file. Each valid word is decoded, executed and retired in the cycle it is presented.

Top module: `rv_alu_exec`

## Requirements
- R1: On reset, and again whenever reset is applied later, every register reads 0x00000000 through the debug port.
- R2: Fields are taken at fixed positions: opcode [6:0], rd [11:7], funct3 [14:12], rs1 [19:15], rs2 [24:20], funct7 [31:25]. For opcode 0110011, funct7=0000000 selects the base operation for funct3, and funct7=0100000 selects SUB (funct3=000) or SRA (funct3=101). Example: 0x408154B3 writes x2 arithmetically shifted right by x8 into x9.
- R3: The register-register funct3 codes are 000 ADD/SUB, 001 SLL, 010 SLT, 011 SLTU, 100 XOR, 101 SRL/SRA, 110 OR and 111 AND.
- R4: For opcode 0010011, funct3 alone selects ADDI, SLTI, SLTIU, XORI, ORI or ANDI (codes 000, 010, 011, 100, 110, 111). The second operand is bits [31:20], sign-extended to 32 bits.
- R5: SLT and SLTI compare as signed numbers. SLTU and SLTIU compare as unsigned numbers, with SLTIU using the sign-extended immediate. Each writes 1 when rs1 is the smaller operand and 0 otherwise.
- R6: A shift uses only the low 5 bits of rs2 or of the immediate. SLLI (funct3=001) needs bits [31:25]=0000000. Funct3=101 gives SRLI when bits [31:25] are 0000000 and SRAI when they are 0100000. Any other value in bits [31:25] of a shift-immediate makes the word illegal.
- R7: x0 always reads zero, and a write with rd=0 leaves every register unchanged.
- R8: Any other opcode raises out_illegal and reports out_kind=00. So does an undefined funct3/funct7 pair within a supported class, but then out_kind still reports the class: 01 for register-register, 10 for register-immediate. An illegal word writes no register.
- R9: The write-back occurs on the rising clock edge while in_valid is 1. While in_valid is 0, no register changes, out_kind is 00 and out_illegal is 0. A word that reads a register written in the previous cycle sees the new value.
- R10: dbg_data shows the register selected by dbg_addr combinationally. In the cycle of a write to that register, dbg_data shows the old value until the edge and the new value after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, clears the register file |
| in_valid | input | 1 | Qualifies in_instr for execution this cycle |
| in_instr | input | 32 | Instruction word |
| dbg_addr | input | 5 | Register index for the debug read |
| dbg_data | output | 32 | Contents of the register selected by dbg_addr |
| out_kind | output | 2 | Class of the presented word: 00 none, 01 register-register, 10 register-immediate |
| out_illegal | output | 1 | Presented valid word is not a supported operation |

## Verification
Two functions can fall in the same cycle: the write-back of one instruction and a read of the same register. The read is either a source operand of the next instruction or the debug port. The stimulus table issues SRA x9,x2,x8 directly after the word that loads x8, so the shift amount is correct only if the register written one cycle earlier is seen. A directed test points dbg_addr at x5 while a write to x5 is pending, then requires the old value before the edge and the new value after it.

// File: rtl/rvx_pkg.sv
package rvx_pkg;

    localparam logic [6:0] OPC_REG = 7'b0110011;
    localparam logic [6:0] OPC_IMM = 7'b0010011;
    localparam logic [6:0] F7_BASE = 7'b0000000;
    localparam logic [6:0] F7_ALT  = 7'b0100000;

    typedef enum logic [3:0] {
        ALU_ADD, ALU_SUB, ALU_SLL, ALU_SLT, ALU_SLTU,
        ALU_XOR, ALU_SRL, ALU_SRA, ALU_OR,  ALU_AND
    } alu_op_e;

    typedef enum logic [1:0] {
        KIND_NONE = 2'b00,
        KIND_REG  = 2'b01,
        KIND_IMM  = 2'b10
    } instr_kind_e;

    typedef struct packed {
        alu_op_e     op;
        instr_kind_e kind;
        logic        illegal;
        logic        use_imm;
        logic [4:0]  rd;
        logic [4:0]  rs1;
        logic [4:0]  rs2;
        logic [11:0] imm;
    } dec_t;

    function automatic alu_op_e base_op(input logic [2:0] f3);
        alu_op_e r;
        unique case (f3)
            3'b000:  r = ALU_ADD;
            3'b001:  r = ALU_SLL;
            3'b010:  r = ALU_SLT;
            3'b011:  r = ALU_SLTU;
            3'b100:  r = ALU_XOR;
            3'b101:  r = ALU_SRL;
            3'b110:  r = ALU_OR;
            default: r = ALU_AND;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/rvx_decode.sv
module rvx_decode
    import rvx_pkg::*;
(
    input  logic [31:0] instr,
    output dec_t        dec
);

    logic [6:0] opc;
    logic [2:0] f3;
    logic [6:0] f7;

    assign opc = instr[6:0];
    assign f3  = instr[14:12];
    assign f7  = instr[31:25];

    always_comb begin
        dec         = '0;
        dec.op      = ALU_ADD;
        dec.kind    = KIND_NONE;
        dec.rd      = instr[11:7];
        dec.rs1     = instr[19:15];
        dec.rs2     = instr[24:20];
        dec.imm     = instr[31:20];
        dec.illegal = 1'b0;
        dec.use_imm = 1'b0;
        unique case (opc)
            OPC_REG: begin
                dec.kind = KIND_REG;
                if (f7 == F7_BASE) begin
                    dec.op = base_op(f3);
                end else if (f7 == F7_ALT && f3 == 3'b000) begin
                    dec.op = ALU_SUB;
                end else if (f7 == F7_ALT && f3 == 3'b101) begin
                    dec.op = ALU_SRA;
                end else begin
                    dec.illegal = 1'b1;
                end
            end
            OPC_IMM: begin
                dec.kind    = KIND_IMM;
                dec.use_imm = 1'b1;
                unique case (f3)
                    3'b001: begin
                        dec.op      = ALU_SLL;
                        dec.illegal = (f7 != F7_BASE);
                    end
                    3'b101: begin
                        if (f7 == F7_BASE)     dec.op = ALU_SRL;
                        else if (f7 == F7_ALT) dec.op = ALU_SRA;
                        else                   dec.illegal = 1'b1;
                    end
                    default: dec.op = base_op(f3);
                endcase
            end
            default: dec.illegal = 1'b1;
        endcase
    end

endmodule

// File: rtl/rvx_alu.sv
module rvx_alu
    import rvx_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  alu_op_e         op,
    input  logic [XLEN-1:0] a,
    input  logic [XLEN-1:0] b,
    output logic [XLEN-1:0] y
);

    localparam int SHW = $clog2(XLEN);

    logic [SHW-1:0] shamt;
    assign shamt = b[SHW-1:0];

    always_comb begin
        unique case (op)
            ALU_ADD:  y = a + b;
            ALU_SUB:  y = a - b;
            ALU_SLL:  y = a << shamt;
            ALU_SLT:  y = {{(XLEN-1){1'b0}}, ($signed(a) < $signed(b))};
            ALU_SLTU: y = {{(XLEN-1){1'b0}}, (a < b)};
            ALU_XOR:  y = a ^ b;
            ALU_SRL:  y = a >> shamt;
            ALU_SRA:  y = $unsigned($signed(a) >>> shamt);
            ALU_OR:   y = a | b;
            default:  y = a & b;
        endcase
    end

endmodule

// File: rtl/rvx_regfile.sv
module rvx_regfile #(
    parameter int XLEN = 32,
    parameter int NREG = 32,
    localparam int AW  = $clog2(NREG)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            we,
    input  logic [AW-1:0]   waddr,
    input  logic [XLEN-1:0] wdata,
    input  logic [AW-1:0]   ra1,
    output logic [XLEN-1:0] rd1,
    input  logic [AW-1:0]   ra2,
    output logic [XLEN-1:0] rd2,
    input  logic [AW-1:0]   ra3,
    output logic [XLEN-1:0] rd3
);

    logic [XLEN-1:0] view [NREG];

    for (genvar i = 0; i < NREG; i++) begin : g_reg
        if (i == 0) begin : g_zero
            assign view[i] = '0;
        end else begin : g_flop
            logic [XLEN-1:0] q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)                         q <= '0;
                else if (we && waddr == AW'(i))     q <= wdata;
            end
            assign view[i] = q;
        end
    end

    assign rd1 = view[ra1];
    assign rd2 = view[ra2];
    assign rd3 = view[ra3];

endmodule

// File: rtl/rv_alu_exec.sv
module rv_alu_exec
    import rvx_pkg::*;
#(
    parameter int XLEN = 32,
    parameter int NREG = 32,
    localparam int AW  = $clog2(NREG),
    localparam int IMMW = 12
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    input  logic [31:0]     in_instr,
    input  logic [AW-1:0]   dbg_addr,
    output logic [XLEN-1:0] dbg_data,
    output logic [1:0]      out_kind,
    output logic            out_illegal
);

    dec_t            dec;
    logic [XLEN-1:0] src1, src2, opnd_b, imm_x, wr_data;
    logic            wr_en;

    rvx_decode u_dec (
        .instr (in_instr),
        .dec   (dec)
    );

    rvx_regfile #(.XLEN(XLEN), .NREG(NREG)) u_rf (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (wr_en),
        .waddr (dec.rd[AW-1:0]),
        .wdata (wr_data),
        .ra1   (dec.rs1[AW-1:0]),
        .rd1   (src1),
        .ra2   (dec.rs2[AW-1:0]),
        .rd2   (src2),
        .ra3   (dbg_addr),
        .rd3   (dbg_data)
    );

    assign imm_x  = {{(XLEN-IMMW){dec.imm[IMMW-1]}}, dec.imm};
    assign opnd_b = dec.use_imm ? imm_x : src2;

    rvx_alu #(.XLEN(XLEN)) u_alu (
        .op (dec.op),
        .a  (src1),
        .b  (opnd_b),
        .y  (wr_data)
    );

    assign wr_en       = in_valid && !dec.illegal && (dec.rd != '0);
    assign out_kind    = in_valid ? dec.kind : KIND_NONE;
    assign out_illegal = in_valid && dec.illegal;

endmodule

// File: rtl/rv_alu_exec_chk.sv
module rv_alu_exec_chk #(
    parameter int XLEN = 32,
    parameter int AW   = 5
) (
    input logic            clk,
    input logic            rst_n,
    input logic            in_valid,
    input logic [4:0]      rd_fld,
    input logic [2:0]      f3_fld,
    input logic [AW-1:0]   dbg_addr,
    input logic [XLEN-1:0] dbg_data,
    input logic [1:0]      out_kind,
    input logic            out_illegal,
    input logic            wr_en,
    input logic [XLEN-1:0] wr_data
);

    // R1
    reset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (dbg_data == '0));

    // R7
    zero_reg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dbg_addr == '0) |-> (dbg_data == '0));

    // R7
    zero_dest_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && rd_fld == 5'd0) |-> !wr_en);

    // R8
    illegal_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_illegal |-> !wr_en);

    // R8
    kind_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(out_kind));

    // R9
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |-> (out_kind == 2'b00 && !out_illegal && !wr_en));

    // R5
    compare_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && f3_fld[2:1] == 2'b01) |-> (wr_data[XLEN-1:1] == '0));

    // R10
    writeback_seen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(wr_en) && $stable(dbg_addr)
         && (dbg_addr == $past(rd_fld[AW-1:0]))) |-> (dbg_data == $past(wr_data)));

endmodule

bind rv_alu_exec rv_alu_exec_chk #(.XLEN(XLEN), .AW(AW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .rd_fld      (in_instr[11:7]),
    .f3_fld      (in_instr[14:12]),
    .dbg_addr    (dbg_addr),
    .dbg_data    (dbg_data),
    .out_kind    (out_kind),
    .out_illegal (out_illegal),
    .wr_en       (wr_en),
    .wr_data     (wr_data)
);

// File: tb/sim_rv_alu_exec.sv
`timescale 1ns/1ps
module sim_rv_alu_exec;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid;
    logic [31:0] in_instr;
    logic [4:0]  dbg_addr;
    logic [31:0] dbg_data;
    logic [1:0]  out_kind;
    logic        out_illegal;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    rv_alu_exec u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_valid    (in_valid),
        .in_instr    (in_instr),
        .dbg_addr    (dbg_addr),
        .dbg_data    (dbg_data),
        .out_kind    (out_kind),
        .out_illegal (out_illegal)
    );

    localparam int NV = 21;
    // Each word is executed and its destination register then read back.
    localparam logic [31:0] V_INS [NV] = '{
        32'hFF000113, // R4 addi x2,x0,-16
        32'h00400413, // R4 addi x8,x0,4
        32'h408154B3, // R2 R9 sra x9,x2,x8 (x8 written one cycle earlier)
        32'h00815533, // R3 srl x10,x2,x8
        32'h402405B3, // R2 sub x11,x8,x2
        32'h00812633, // R5 slt x12,x2,x8
        32'h008136B3, // R5 sltu x13,x2,x8
        32'h00F43693, // R5 sltiu x13,x8,15
        32'hFFF13713, // R5 sltiu x14,x2,-1
        32'hFFF12793, // R5 slti x15,x2,-1
        32'h0FF14813, // R4 xori x16,x2,0xff
        32'h80046893, // R4 ori x17,x8,-2048
        32'h07F17913, // R4 andi x18,x2,0x7f
        32'h01D41993, // R6 slli x19,x8,29
        32'h40215A13, // R6 srai x20,x2,2
        32'h01C15A93, // R6 srli x21,x2,28
        32'h00241B33, // R6 sll x22,x8,x2 (amount 16)
        32'h00814BB3, // R3 xor x23,x2,x8
        32'h00856C33, // R3 or x24,x10,x8
        32'h00A17CB3, // R3 and x25,x2,x10
        32'h00100133  // R2 add x2,x0,x1
    };
    localparam logic [31:0] V_EXP [NV] = '{
        32'hFFFFFFF0, 32'h00000004, 32'hFFFFFFFF, 32'h0FFFFFFF,
        32'h00000014, 32'h00000001, 32'h00000000, 32'h00000001,
        32'h00000001, 32'h00000001, 32'hFFFFFF0F, 32'hFFFFF804,
        32'h00000070, 32'h80000000, 32'hFFFFFFFC, 32'h0000000F,
        32'h00040000, 32'hFFFFFFF4, 32'h0FFFFFFF, 32'h0FFFFFF0,
        32'h00000000
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    // Present a word at the falling edge; combinational outputs settle 1 ns later.
    task automatic drive(input logic [31:0] ins, input logic v);
        in_instr = ins;
        in_valid = v;
        #1;
    endtask

    // Pass the rising edge and return to the next falling edge.
    task automatic step();
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic peek(input logic [4:0] a);
        dbg_addr = a;
        #1;
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        #800000;
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
        end
    end

    initial begin
        rst_n    = 1'b0;
        in_valid = 1'b0;
        in_instr = 32'h0;
        dbg_addr = 5'd0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: every register cleared after reset
        for (int i = 0; i < 32; i++) begin
            peek(5'(i));
            chk("R1 reset value", dbg_data, 32'h0);
        end
        chk("R9 idle kind/illegal", {29'h0, out_kind, out_illegal}, 32'h0);

        // Table walk
        for (int k = 0; k < NV; k++) begin
            drive(V_INS[k], 1'b1);
            chk("R8 class report", {29'h0, out_kind, out_illegal},
                {29'h0, (V_INS[k][6:0] == 7'h33) ? 2'b01 : 2'b10, 1'b0});
            step();
            peek(V_INS[k][11:7]);
            chk($sformatf("R2-table entry %0d", k), dbg_data, V_EXP[k]);
        end

        // R7: write to x0 is dropped
        drive(32'h00500013, 1'b1);
        chk("R7 addi x0 is legal", {29'h0, out_kind, out_illegal}, 32'h4);
        step();
        peek(5'd0);
        chk("R7 x0 stays zero", dbg_data, 32'h0);

        // Set x5 = 7 for the suppression tests
        drive(32'h00700293, 1'b1);
        step();
        peek(5'd5);
        chk("R4 addi x5,x0,7", dbg_data, 32'h7);

        // R8: unsupported opcode (0110111)
        drive(32'h000052B7, 1'b1);
        chk("R8 unsupported opcode flags", {29'h0, out_kind, out_illegal}, 32'h1);
        step();
        chk("R8 unsupported opcode no write", dbg_data, 32'h7);

        // R8: register-register with funct7=0000001
        drive(32'h028402B3, 1'b1);
        chk("R8 bad funct7 flags", {29'h0, out_kind, out_illegal}, 32'h3);
        step();
        chk("R8 bad funct7 no write", dbg_data, 32'h7);

        // R6: slli with bits[31:25]=0100000 is illegal
        drive(32'h40041293, 1'b1);
        chk("R6 bad slli flags", {29'h0, out_kind, out_illegal}, 32'h5);
        step();
        chk("R6 bad slli no write", dbg_data, 32'h7);

        // R9: valid low, no write, quiet outputs
        drive(32'h00900293, 1'b0);
        chk("R9 invalid word quiet", {29'h0, out_kind, out_illegal}, 32'h0);
        step();
        chk("R9 invalid word no write", dbg_data, 32'h7);

        // R10: write and debug read of the same register in one cycle
        drive(32'h05500293, 1'b1);
        chk("R10 old value before edge", dbg_data, 32'h7);
        step();
        chk("R10 new value after edge", dbg_data, 32'h55);

        // R6: register shift amount 33 uses only the low five bits
        drive(32'h02100D93, 1'b1);
        step();
        drive(32'h01B41D33, 1'b1);
        step();
        peek(5'd26);
        chk("R6 shift amount low bits", dbg_data, 32'h8);

        // R1: a later reset clears the written state
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        for (int i = 0; i < 32; i++) begin
            peek(5'(i));
            chk("R1 re-reset value", dbg_data, 32'h0);
        end
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        done = 1'b1;
        summary();
    end

endmodule